// File: doc/BRIEF.md
# Offset-Adjusted Deadline Timer

This block keeps a free-running 64-bit raw counter and a software-writable offset. Software sees a timestamp equal to the raw counter plus the offset. It also has a one-shot deadline: software writes a deadline, and the block raises a single-cycle interrupt pulse when the deadline is reached, then disarms itself.

The compare target is set once, when the deadline is written. At that moment the block takes the written deadline, subtracts the offset then in force, and stores the result. From then on it compares that stored target against the raw counter. If the offset changes after arming, the target stays where it was. The interrupt therefore arrives early or late when measured against the visible timestamp. Raising the offset by 100 after arming makes the pulse appear when the visible timestamp is 100 past the deadline.

Registers are reached through a plain single-cycle write strobe and a combinational read mux. These are control pins, so there is no valid/ready handshake and no back-pressure. A write takes effect at the next rising clock edge.

Top module: `tsc_deadline_timer`

## Requirements
- R1: After reset, the timestamp, offset and deadline all read as 0 and `irq` is low.
- R2: The raw counter advances by exactly one on every clock edge where `cnt_en` is high. It holds its value when `cnt_en` is low.
- R3: Address 0 reads the timestamp, which is the raw counter plus the offset, modulo 2^64. Address 1 reads and writes the offset. Address 3 reads 0.
- R4: A write to address 2 stores target = (written value − offset) modulo 2^64 and arms the timer if the written value is non-zero. While armed, `irq` is high in the cycle after the first clock edge at which the raw counter is unsigned greater than or equal to the target.
- R5: Writing the offset while armed leaves the stored target unchanged, so the pulse timing depends only on the raw counter.
- R6: Each arming gives exactly one pulse, one cycle wide. At that same edge the timer disarms and the deadline register becomes 0.
- R7: Writing a deadline of 0 disarms the timer, and no interrupt follows.
- R8: A target already at or below the raw counter fires on the next edge. A target that wraps past 2^64 is compared as a plain unsigned number, with no sign extension.
- R9: While armed, address 2 reads back the value software wrote, not the stored target.
- R10: A write to address 0 or address 3 has no effect on any register. If a deadline write and a firing condition fall on the same edge, the write wins and no pulse is produced.

Ports
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Raw counter advance enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 timestamp, 1 offset, 2 deadline) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle deadline pulse |

## Verification
If the stored target is wrong, the pulse comes earlier or later than the count predicted from the raw counter. If the armed flag is wrong, the pulse is missing or repeated. Either error shows at `irq` within the cycle-by-cycle window that the bench tracks after each arming. A wrong offset or counter shows on the very next timestamp read. A failed disarm shows as a non-zero deadline readback one cycle after the pulse.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TW = 64;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] A_STAMP = 2'd0;
  localparam logic [AW-1:0] A_OFFS  = 2'd1;
  localparam logic [AW-1:0] A_DLINE = 2'd2;
  localparam logic [AW-1:0] A_NONE  = 2'd3;
endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else if (en) raw <= raw + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tsc_offset.sv
module tsc_offset #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raw,
  output logic [W-1:0] offs,
  output logic [W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offs <= '0;
    else if (wr) offs <= wdata;
  end
  // modulo 2^W sum, no sign handling
  assign stamp = raw + offs;
endmodule

// File: rtl/tsc_deadline.sv
module tsc_deadline #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] offs,
  input  logic [W-1:0] raw,
  output logic [W-1:0] dl_sw,
  output logic [W-1:0] target,
  output logic         armed,
  output logic         fire
);
  logic reach;
  assign reach = armed && (raw >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_sw  <= '0;
      target <= '0;
      armed  <= 1'b0;
      fire   <= 1'b0;
    end else if (wr) begin
      dl_sw  <= wdata;
      target <= wdata - offs;
      armed  <= |wdata;
      fire   <= 1'b0;
    end else begin
      fire <= reach;
      if (reach) begin
        armed <= 1'b0;
        dl_sw <= '0;
      end
    end
  end
endmodule

// File: rtl/tsc_deadline_timer.sv
module tsc_deadline_timer
  import tsc_pkg::*;
#(
  parameter int unsigned W = TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          irq
);
  logic [W-1:0] raw, offs, stamp, dl_sw, target;
  logic armed;
  logic wr_offs, wr_dl;

  assign wr_offs = reg_wr && (reg_addr == A_OFFS);
  assign wr_dl   = reg_wr && (reg_addr == A_DLINE);

  tsc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .raw(raw)
  );

  tsc_offset #(.W(W)) u_offs (
    .clk(clk), .rst_n(rst_n), .wr(wr_offs), .wdata(reg_wdata),
    .raw(raw), .offs(offs), .stamp(stamp)
  );

  tsc_deadline #(.W(W)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr(wr_dl), .wdata(reg_wdata),
    .offs(offs), .raw(raw), .dl_sw(dl_sw), .target(target),
    .armed(armed), .fire(irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_STAMP: reg_rdata = stamp;
      A_OFFS:  reg_rdata = offs;
      A_DLINE: reg_rdata = dl_sw;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsc_deadline_timer_chk.sv
module tsc_deadline_timer_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         irq,
  input logic [W-1:0] raw,
  input logic [W-1:0] target,
  input logic [W-1:0] dl_sw,
  input logic         armed
);
  logic dlw;
  assign dlw = reg_wr && (reg_addr == 2'd2);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> raw == $past(raw) + 1) else $error("cnt step"); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(raw)) else $error("cnt hold"); // R2
  AST_FIRE_ON_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && raw >= target && !dlw) |=> irq) else $error("no fire"); // R4
  AST_TARGET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dlw |=> $stable(target)) else $error("target moved"); // R5
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("wide pulse"); // R6
  AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!armed && dl_sw == '0)) else $error("not disarmed"); // R6
  AST_ZERO_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dlw && reg_wdata == '0) |=> (!irq && !armed)) else $error("zero armed"); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dlw |=> !irq) else $error("fire on write"); // R10
endmodule

bind tsc_deadline_timer tsc_deadline_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .raw(raw), .target(target), .dl_sw(dl_sw), .armed(armed)
);

// File: tb/sim_tsc_deadline_timer.sv
`timescale 1ns/1ps
module sim_tsc_deadline_timer;
  localparam int W = 64;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0] m_raw = '0, m_adj = '0, m_tgt = '0, m_dl = '0;
  bit m_armed = 1'b0, m_irq = 1'b0;

  always #4 clk = ~clk;

  tsc_deadline_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive inputs, let the edge pass, update the model, check irq
  task automatic step(input bit wr, input logic [1:0] a, input logic [W-1:0] d, input string req);
    bit fire, dlw;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    dlw  = wr && a == 2'd2;
    fire = m_armed && (m_raw >= m_tgt) && !dlw;
    if (wr && a == 2'd1) m_adj = d;
    if (dlw) begin
      m_tgt = d - m_adj; m_dl = d; m_armed = (d != 0);
    end else if (fire) begin
      m_armed = 1'b0; m_dl = '0;
    end
    if (cnt_en) m_raw = m_raw + 1;
    m_irq = fire;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(req, {63'd0, irq}, {63'd0, m_irq});
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, '0, "R1"); rd(2'd1, '0, "R1"); rd(2'd2, '0, "R1");
    chk("R1", {63'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 hold when disabled, then advance
    repeat (3) step(0, 2'd0, '0, "R2");
    rd(2'd0, '0, "R2");
    cnt_en = 1'b1;
    repeat (5) step(0, 2'd0, '0, "R2");
    rd(2'd0, 64'd5, "R2");
    // R3 offset and sum, including wrap
    step(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFE, "R3");
    rd(2'd1, 64'hFFFF_FFFF_FFFF_FFFE, "R3");
    rd(2'd0, m_raw + m_adj, "R3");
    rd(2'd3, '0, "R3");
    step(1, 2'd1, '0, "R3");
    // R10 writes to read-only addresses are ignored
    step(1, 2'd0, 64'h1234, "R10");
    step(1, 2'd3, 64'h5678, "R10");
    rd(2'd0, m_raw, "R10"); rd(2'd1, '0, "R10"); rd(2'd2, '0, "R10");
    // R4/R5/R6/R8/R9 sweep: deadline offsets vs. later offset changes
    for (int off = -4; off <= 12; off++) begin
      for (int k = 0; k < 4; k++) begin
        logic [W-1:0] dl, adj2;
        dl = m_raw + m_adj + W'(off);
        adj2 = (k == 0) ? m_adj : (k == 1) ? m_adj + 64'd7 :
               (k == 2) ? m_adj - 64'd5 : 64'h8000_0000_0000_0000;
        if (dl == '0) dl = 64'd1;
        step(1, 2'd2, dl, "R4");
        if (m_armed) rd(2'd2, dl, "R9");
        step(1, 2'd1, adj2, "R5");
        for (int c = 0; c < 24; c++) step(0, 2'd0, '0, "R6");
        rd(2'd2, m_dl, "R6");
        if (m_armed) begin
          step(1, 2'd2, '0, "R7");
          rd(2'd2, '0, "R7");
        end
        step(1, 2'd1, '0, "R5");
      end
    end
    // R8 wrapped target: big offset makes small deadline a far target
    step(1, 2'd1, 64'hFFFF_FFFF_FFFF_0000, "R8");
    step(1, 2'd2, 64'd3, "R8");
    rd(2'd2, 64'd3, "R8");
    repeat (20) step(0, 2'd0, '0, "R8");
    step(1, 2'd2, '0, "R7");
    repeat (5) step(0, 2'd0, '0, "R7");
    // R8 past target: fires on the next edge
    step(1, 2'd1, '0, "R8");
    step(1, 2'd2, 64'd1, "R8");
    step(0, 2'd0, '0, "R8");
    chk("R8", {63'd0, irq}, 64'd1);
    step(0, 2'd0, '0, "R6");
    // R10 write on the firing edge wins
    step(1, 2'd2, 64'd1, "R10");
    step(1, 2'd2, 64'd2, "R10");
    step(0, 2'd0, '0, "R10");
    step(0, 2'd0, '0, "R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule